// File: doc/BRIEF.md
# One-Bit Stream Decimating FIR

This block is the first decimation stage behind a sigma-delta modulator. It takes a single-bit oversampled stream, qualified by a valid strobe. For every 32 accepted bits it produces one signed multi-bit sample, marked by a one-cycle valid pulse. Each sample is a 256-tap FIR with 16-bit coefficients evaluated over the most recent 256 accepted bits. Each bit is read as bipolar: a 1 stands for +1 and a 0 stands for −1. Each tap therefore either adds or subtracts its coefficient, and the block has no multipliers.

Decimation is folded into the filter. Eight accumulators run at once, each collecting one 256-bit window, with their start points staggered by 32 bits. On every accepted bit, each accumulator adds the coefficient that matches its own position in its window. When a 32-bit group completes, the oldest accumulator holds a finished sum. That sum becomes the output, the accumulator is cleared, and it starts the next window. Only the retained samples are ever computed, and the input bits are never stored.

Top module: `dec1b_fir`

## Requirements
- R1: After every 32nd accepted bit (counted from reset), `out_valid` is high for exactly one cycle, in the cycle after the clock edge that accepted that bit. At no other time is it high.
- R2: A sample emitted after accepted bit number n (counting from 1) equals the sum over j = 0..255 of s(j)·c[j]. Here s(j) = +1 when accepted bit n−255+j is 1 and −1 when it is 0. Bit n−255 is the oldest in the window and is weighted by c[0].
- R3: The coefficient table is c[i] = (m+1)·240 − 6000, with m = i for i < 128 and m = 255 − i otherwise. Every entry fits in 16 bits signed.
- R4: No sample is emitted until 256 bits have been accepted since reset. The first valid pulse follows the 256th accepted bit.
- R5: A cycle with `in_valid` low is ignored. The level of `in_bit` in that cycle has no effect, the group position does not advance, and `out_data` keeps its value.
- R6: While `rst_n` is low, `out_valid` and `out_data` are 0. A reset in the middle of a stream discards all partial windows, and R4 applies again from the release.
- R7: `out_data` is 24 bits two's complement and holds every reachable sum without wrapping, including an all-ones or all-zeros window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | One-bit stream sample (1 = +1, 0 = −1) |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_data | output | 24 | Signed filtered output sample |

## Verification
The hardest situation to reach from the ports is a stall that falls right at a group boundary, with the 32nd bit of a group arriving after an idle stretch. The eight accumulators must keep their phase alignment through such a gap. To reach it, the stimulus runs a long random stretch in which roughly a quarter of the cycles are idle and the idle cycles carry random `in_bit` levels. The bench compares every emitted sample against a convolution that it computes itself over its own record of the accepted bits. A reset in the middle of a stream, part way through a group, checks that the 256-bit warm-up starts over.

// File: rtl/dec1b_pkg.sv
package dec1b_pkg;
  localparam int COEF_W    = 16;
  localparam int COEF_STEP = 240;
  localparam int COEF_OFS  = 6000;

  // Symmetric triangular tap weight, folded around the centre of the table.
  function automatic logic [COEF_W-1:0] coef_at(input int idx, input int taps);
    int m;
    int v;
    m = (idx < taps / 2) ? idx : (taps - 1 - idx);
    v = (m + 1) * COEF_STEP - COEF_OFS;
    return v[COEF_W-1:0];
  endfunction
endpackage

// File: rtl/dec1b_seq.sv
module dec1b_seq #(
  parameter int DECIM = 32,
  parameter int NACC  = 8,
  localparam int PH_W  = $clog2(DECIM),
  localparam int PTR_W = $clog2(NACC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  output logic [PH_W-1:0]  phase,
  output logic [PTR_W-1:0] ptr,
  output logic             group_end,
  output logic             emit_ok
);
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] fill_q, fill_d;

  assign group_end = (phase_q == PH_W'(DECIM - 1));
  assign emit_ok   = (fill_q == PTR_W'(NACC - 1));
  assign phase     = phase_q;
  assign ptr       = ptr_q;

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    fill_d  = fill_q;
    if (in_fire) begin
      if (group_end) begin
        phase_d = '0;
        ptr_d   = ptr_q + 1'b1;
        if (!emit_ok) fill_d = fill_q + 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ptr_q   <= '0;
      fill_q  <= '0;
    end else if (in_fire) begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
      fill_q  <= fill_d;
    end
  end
endmodule

// File: rtl/dec1b_coef_bank.sv
module dec1b_coef_bank
  import dec1b_pkg::*;
#(
  parameter int TAPS  = 256,
  parameter int DECIM = 32,
  localparam int NACC = TAPS / DECIM,
  localparam int PH_W = $clog2(DECIM)
) (
  input  logic [PH_W-1:0]                  phase,
  output logic [NACC-1:0][COEF_W-1:0]      coef_by_age
);
  // One lookup per window age: age g uses tap g*DECIM + phase.
  for (genvar g = 0; g < NACC; g++) begin : g_age
    always_comb begin
      coef_by_age[g] = coef_at(g * DECIM + int'(phase), TAPS);
    end
  end
endmodule

// File: rtl/dec1b_acc_bank.sv
module dec1b_acc_bank
  import dec1b_pkg::*;
#(
  parameter int NACC  = 8,
  parameter int ACC_W = 24,
  localparam int PTR_W = $clog2(NACC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_fire,
  input  logic                        in_bit,
  input  logic [PTR_W-1:0]            ptr,
  input  logic                        group_end,
  input  logic                        emit_ok,
  input  logic [NACC-1:0][COEF_W-1:0] coef_by_age,
  output logic                        out_valid,
  output logic [ACC_W-1:0]            out_data
);
  logic [NACC-1:0][ACC_W-1:0] sum_all;
  logic [PTR_W-1:0]           oldest;
  logic                       emit;
  logic                       vld_q, vld_d;
  logic [ACC_W-1:0]           dat_q, dat_d;

  for (genvar a = 0; a < NACC; a++) begin : g_acc
    logic [PTR_W-1:0] age;
    logic [ACC_W-1:0] coef_ext, term, sum_w, acc_q, acc_d;
    logic [COEF_W-1:0] coef_sel;

    always_comb begin
      age      = ptr - PTR_W'(a);
      coef_sel = coef_by_age[age];
      coef_ext = {{(ACC_W - COEF_W){coef_sel[COEF_W-1]}}, coef_sel};
      term     = in_bit ? coef_ext : (~coef_ext + 1'b1);
      sum_w    = acc_q + term;
      acc_d    = acc_q;
      if (in_fire) begin
        acc_d = (group_end && (age == PTR_W'(NACC - 1))) ? '0 : sum_w;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end

    assign sum_all[a] = sum_w;
  end

  assign oldest = ptr + 1'b1;
  assign emit   = in_fire && group_end && emit_ok;

  always_comb begin
    vld_d = emit;
    dat_d = emit ? sum_all[oldest] : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/dec1b_fir.sv
module dec1b_fir
  import dec1b_pkg::*;
#(
  parameter int TAPS  = 256,
  parameter int DECIM = 32,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_data
);
  localparam int NACC  = TAPS / DECIM;
  localparam int PH_W  = $clog2(DECIM);
  localparam int PTR_W = $clog2(NACC);

  logic [PH_W-1:0]             phase;
  logic [PTR_W-1:0]            ptr;
  logic                        group_end;
  logic                        emit_ok;
  logic [NACC-1:0][COEF_W-1:0] coef_by_age;

  dec1b_seq #(.DECIM(DECIM), .NACC(NACC)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (in_valid),
    .phase     (phase),
    .ptr       (ptr),
    .group_end (group_end),
    .emit_ok   (emit_ok)
  );

  dec1b_coef_bank #(.TAPS(TAPS), .DECIM(DECIM)) coef_i (
    .phase       (phase),
    .coef_by_age (coef_by_age)
  );

  dec1b_acc_bank #(.NACC(NACC), .ACC_W(ACC_W)) acc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_fire     (in_valid),
    .in_bit      (in_bit),
    .ptr         (ptr),
    .group_end   (group_end),
    .emit_ok     (emit_ok),
    .coef_by_age (coef_by_age),
    .out_valid   (out_valid),
    .out_data    (out_data)
  );
endmodule

// File: rtl/dec1b_fir_chk.sv
module dec1b_fir_chk #(
  parameter int TAPS  = 256,
  parameter int DECIM = 32,
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_data
);
  localparam int CW = $clog2(TAPS) + 2;

  logic [CW-1:0] fire_cnt;
  logic [CW-1:0] since_out;
  logic          seen_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_cnt  <= '0;
      since_out <= '0;
      seen_out  <= 1'b0;
    end else begin
      if (in_valid && (fire_cnt < CW'(TAPS))) fire_cnt <= fire_cnt + 1'b1;
      if (out_valid) begin
        since_out <= in_valid ? CW'(1) : '0;
        seen_out  <= 1'b1;
      end else if (in_valid && (since_out < CW'(TAPS))) begin
        since_out <= since_out + 1'b1;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R1
  AST_GROUP_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && seen_out) |-> (since_out == CW'(DECIM))); // R1
  AST_NO_EARLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (fire_cnt >= CW'(TAPS))); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_data)); // R5
endmodule

bind dec1b_fir dec1b_fir_chk #(.TAPS(TAPS), .DECIM(DECIM), .ACC_W(ACC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/dec1b_fir_tb_top.sv
module dec1b_fir_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_bit;
  logic        out_valid;
  logic [23:0] out_data;

  int checks;
  int errors;
  int cnt;
  int cnt_seen;
  bit done;
  bit hist [0:8191];
  logic [23:0] last_data;
  bit   acc_now;
  bit   exp_v;
  int   exp_sum;

  dec1b_fir dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ref_coef(int j);
    int m;
    m = (j < 128) ? j : 255 - j;
    return (m + 1) * 240 - 6000;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expd);
    end
  endtask

  task automatic send(bit b, bit v);
    @(negedge clk);
    in_valid = v;
    in_bit   = v ? b : 1'($urandom);
    if (v) begin
      hist[cnt] = b;
      cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    cnt      = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor samples 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      check(out_valid == 1'b0 && out_data == 24'd0, "R6", {out_valid, out_data}, 0);
      cnt_seen  = 0;
      last_data = '0;
    end else begin
      acc_now = (cnt != cnt_seen);
      exp_v   = acc_now && (cnt % 32 == 0) && (cnt >= 256);
      check(out_valid == exp_v, "R1 R4 valid pulse", out_valid, exp_v);
      if (out_valid && exp_v) begin
        exp_sum = 0;
        for (int j = 0; j < 256; j++)
          exp_sum += hist[cnt - 256 + j] ? ref_coef(j) : -ref_coef(j);
        check($signed(out_data) == exp_sum, "R2 R3 R7 sample value", $signed(out_data), exp_sum);
        last_data = out_data;
      end else if (!out_valid) begin
        check(out_data == last_data, "R5 hold", out_data, last_data);
      end
      cnt_seen = cnt;
    end
  end

  initial begin
    checks = 0; errors = 0; cnt = 0; cnt_seen = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 extremes: all ones then all zeros.
    repeat (320) send(1'b1, 1'b1);
    repeat (320) send(1'b0, 1'b1);
    for (int i = 0; i < 320; i++) send(1'(i % 2), 1'b1);
    // R5: random stalls with junk bits on idle cycles.
    for (int i = 0; i < 1600; i++) send(1'($urandom), ($urandom % 4) != 0);
    repeat (40) send(1'b0, 1'b0);
    // R6: reset part way through a group, warm-up restarts.
    for (int i = 0; i < 117; i++) send(1'($urandom), 1'b1);
    do_reset();
    for (int i = 0; i < 700; i++) send(1'($urandom), ($urandom % 3) != 0);
    for (int i = 0; i < 200; i++) send(1'($urandom), 1'b1);
    repeat (6) send(1'b0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule